// File: doc/BRIEF.md
# PHY Management Access Bridge

The bridge lets host software reach the management registers of an external PHY through a single 32-bit access word. A host write to the word starts one serial management frame on the clock and data pins of the management interface, using the standard clause 22 framing. When bit 31 of the written value is 1, the frame writes the 16-bit data field to the selected PHY register. When bit 31 is 0, the frame reads that register.

Software learns that the frame has finished by polling bit 31 of the same word. The flag's meaning depends on the operation. For a write, bit 31 stays 1 while the frame runs, and hardware clears it when the frame ends. For a read, bit 31 stays 0 until the returned data sits in bits [15:0], and hardware then sets it. Completion takes 64 management clock periods, which is a few tens of microseconds at the default divider.

The PHY address is fixed by a parameter. The management clock is the system clock divided by `CLK_DIV`. The bridge drives data while the management clock is low and samples read data on its rising edge.

Top module: `mdio_bridge`

## Requirements
- R1: After reset the access word reads 0, the management clock is low and the bridge does not drive the data pin.
- R2: A write frame carries, most significant bit first, 32 ones, start 01, opcode 01, the 5-bit `PHY_ADDR`, the register address from access bits [20:16], turnaround 10 and the 16 data bits from access bits [15:0].
- R3: During a write frame bit 31 reads 1. When the frame ends bit 31 reads 0, and the address and data fields keep the written values.
- R4: A read frame uses opcode 10. The bridge stops driving the data pin from the first turnaround bit to the end of the frame, which is 18 bit times.
- R5: At the end of a read frame, bits [15:0] hold the 16 bits sampled on the rising management clock edges of the data phase, most significant first, and bit 31 reads 1.
- R6: The management clock has a period of `CLK_DIV` system clock cycles with equal high and low halves. It gives exactly 64 rising edges per frame and stays low when no frame is running.
- R7: A host write that arrives while a frame runs is dropped. The access word, the frame on the pins and the PHY register contents are unaffected by it.
- R8: Access bits [30:21] always read 0, whatever value was written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | One-cycle strobe that writes the access word |
| host_wdata | input | 32 | Value written to the access word |
| host_rdata | output | 32 | Current access word: flag, register address and data |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Data bit driven toward the PHY |
| mdio_oe | output | 1 | Output enable for the data pin |
| mdio_i | input | 1 | Value of the data pin as seen by the bridge |

## Verification
The assertions check on every cycle the following properties:
- the management clock is quiet and the pin is released while idle;
- the flag stays put during a frame;
- the flag moves in the right direction for each operation at the frame's end;
- a dropped host write leaves the word unchanged;
- the pin is released in the read data phase.

Some behaviour only the bench's scenarios can show, using a PHY model that decodes the frames:
- the exact bit content of each frame;
- the clock period and the count of 64 edges per frame;
- that read data arrives in the right bit order;
- that a write lands in the intended PHY register and a dropped write never reaches the PHY.

// File: rtl/mdio_bridge.sv
module mdio_bridge #(
  parameter int          CLK_DIV  = 40,
  parameter logic [4:0]  PHY_ADDR = 5'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int HALF      = (CLK_DIV / 2 > 0) ? CLK_DIV / 2 : 1;
  localparam int DW        = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int NBITS     = 64;
  localparam int TA_FIRST  = 46;
  localparam int DATA_FIRST = 48;

  logic        flag;
  logic        op_wr;
  logic        busy;
  logic [4:0]  reg_a;
  logic [15:0] data;
  logic [15:0] rd_sh;
  logic [5:0]  bit_cnt;
  logic [DW-1:0] div_cnt;

  wire tick = busy && (div_cnt == DW'(HALF - 1));
  wire rise = tick && !mdc;
  wire fall = tick && mdc;
  wire fin  = fall && (bit_cnt == 6'(NBITS - 1));

  wire [NBITS-1:0] frame = {32'hFFFF_FFFF, 2'b01, (op_wr ? 2'b01 : 2'b10),
                            PHY_ADDR, reg_a, 2'b10, data};

  assign mdio_o     = frame[6'(NBITS - 1) - bit_cnt];
  assign mdio_oe    = busy && (op_wr || (bit_cnt < 6'(TA_FIRST)));
  assign host_rdata = {flag, 10'd0, reg_a, data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag    <= 1'b0;
      op_wr   <= 1'b0;
      busy    <= 1'b0;
      reg_a   <= '0;
      data    <= '0;
      rd_sh   <= '0;
      bit_cnt <= '0;
      div_cnt <= '0;
      mdc     <= 1'b0;
    end else if (!busy) begin
      if (host_wr) begin
        flag    <= host_wdata[31];
        op_wr   <= host_wdata[31];
        reg_a   <= host_wdata[20:16];
        data    <= host_wdata[15:0];
        busy    <= 1'b1;
        bit_cnt <= '0;
        div_cnt <= '0;
      end
    end else begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (tick)
        mdc <= !mdc;
      if (rise && !op_wr && bit_cnt >= 6'(DATA_FIRST))
        rd_sh <= {rd_sh[14:0], mdio_i};
      if (fall)
        bit_cnt <= bit_cnt + 1'b1;
      if (fin) begin
        busy <= 1'b0;
        flag <= !op_wr;
        if (!op_wr)
          data <= rd_sh;
      end
    end
  end
endmodule

module mdio_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_wr,
  input logic [31:0] host_wdata,
  input logic [31:0] host_rdata,
  input logic        busy,
  input logic        fin,
  input logic        op_wr,
  input logic        mdc,
  input logic        mdio_oe,
  input logic [5:0]  bit_cnt
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!mdc && !mdio_oe)); // R6
  AST_BUSY_DROPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (busy && host_wr && !fin) |=> $stable(host_rdata)); // R7
  AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n) (busy && !fin) |=> $stable(host_rdata[31])); // R3
  AST_WRITE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (fin && op_wr) |=> !host_rdata[31]); // R3
  AST_READ_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (fin && !op_wr) |=> host_rdata[31]); // R5
  AST_READ_RELEASES_PIN: assert property (@(posedge clk) disable iff (!rst_n) (busy && !op_wr && bit_cnt >= 6'd46) |-> !mdio_oe); // R4
  AST_START_LATCHES: assert property (@(posedge clk) disable iff (!rst_n) (!busy && host_wr) |=> (busy && host_rdata[20:0] == $past(host_wdata[20:0]))); // R2
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) host_wr |=> host_rdata[30:21] == 10'd0); // R8
endmodule

bind mdio_bridge mdio_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
  .host_rdata(host_rdata), .busy(busy), .fin(fin), .op_wr(op_wr),
  .mdc(mdc), .mdio_oe(mdio_oe), .bit_cnt(bit_cnt)
);

// File: tb/mdio_bridge_bench.sv
`timescale 1ns/1ps
module mdio_bridge_bench;
  localparam int         CLK_DIV  = 40;
  localparam logic [4:0] PHY_ADDR = 5'd1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        phy_oe = 1'b0, phy_o = 1'b1;
  wire         mdio_line = mdio_oe ? mdio_o : (phy_oe ? phy_o : 1'b1);

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  mdio_bridge #(.CLK_DIV(CLK_DIV), .PHY_ADDR(PHY_ADDR)) u_mdio_bridge (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_line)
  );

  logic [15:0] phy_regs [32];
  logic [63:0] fb = '0, last_frame = '0;
  int          rcnt = 0, frames = 0;
  logic        contention = 1'b0;
  logic [1:0]  m_op = 2'b00;
  logic [4:0]  m_reg = '0;
  logic [15:0] m_rd = '0;
  realtime     last_rise = 0, per_min = 1e9, per_max = 0;

  always @(posedge mdc) begin
    if (phy_oe && mdio_oe) contention = 1'b1;
    if (rcnt != 0) begin
      if ($realtime - last_rise < per_min) per_min = $realtime - last_rise;
      if ($realtime - last_rise > per_max) per_max = $realtime - last_rise;
    end
    last_rise = $realtime;
    fb = {fb[62:0], mdio_line};
    rcnt++;
    if (rcnt == 36) m_op = fb[1:0];
    if (rcnt == 46) begin
      m_reg = fb[4:0];
      m_rd  = phy_regs[m_reg];
    end
    if (rcnt == 64) begin
      last_frame = fb;
      frames++;
      if (m_op == 2'b01) phy_regs[m_reg] = fb[15:0];
      rcnt = 0;
    end
  end

  always @(negedge mdc) begin
    if (m_op == 2'b10 && rcnt >= 47 && rcnt <= 63) begin
      phy_oe = 1'b1;
      phy_o  = (rcnt == 47) ? 1'b0 : m_rd[63 - rcnt];
    end else begin
      phy_oe = 1'b0;
      phy_o  = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(input bit wr, input logic [4:0] ra, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), PHY_ADDR, ra, 2'b10, d};
  endfunction

  task automatic host_write(input logic [31:0] v);
    @(negedge clk);
    host_wr = 1'b1;
    host_wdata = v;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic wait_flag(input bit val, input string tag);
    int n = 0;
    while (host_rdata[31] !== val && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 5000, tag, 64'(host_rdata[31]), 64'(val));
  endtask

  task automatic t_reset();
    chk(host_rdata == 32'd0, "R1 word", 64'(host_rdata), 64'd0);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins", {62'd0, mdc, mdio_oe}, 64'd0);
  endtask

  task automatic t_write(input logic [4:0] ra, input logic [15:0] d);
    int f0 = frames;
    host_write({1'b1, 10'h3FF, ra, d});
    chk(host_rdata[31] == 1'b1, "R3 flag during write", 64'(host_rdata[31]), 64'd1);
    wait_flag(1'b0, "R3 write completes");
    chk(host_rdata == {1'b0, 10'd0, ra, d}, "R3/R8 word after write", 64'(host_rdata), 64'({1'b0, 10'd0, ra, d}));
    chk(last_frame == exp_frame(1'b1, ra, d), "R2 write frame", last_frame, exp_frame(1'b1, ra, d));
    chk(phy_regs[ra] == d, "R2 phy register", 64'(phy_regs[ra]), 64'(d));
    chk(frames == f0 + 1, "R6 one frame", 64'(frames), 64'(f0 + 1));
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R6 idle after write", {62'd0, mdc, mdio_oe}, 64'd0);
  endtask

  task automatic t_read(input logic [4:0] ra, input logic [15:0] d);
    contention = 1'b0;
    phy_regs[ra] = d;
    host_write({1'b0, 10'h155, ra, 16'hABCD});
    chk(host_rdata[31] == 1'b0, "R5 flag low during read", 64'(host_rdata[31]), 64'd0);
    wait_flag(1'b1, "R5 read completes");
    chk(host_rdata == {1'b1, 10'd0, ra, d}, "R5/R8 read word", 64'(host_rdata), 64'({1'b1, 10'd0, ra, d}));
    chk(last_frame == exp_frame(1'b0, ra, d), "R4 read frame", last_frame, exp_frame(1'b0, ra, d));
    chk(!contention, "R4 pin released", 64'(contention), 64'd0);
  endtask

  task automatic t_busy_drop();
    int f0 = frames;
    logic [15:0] keep0 = phy_regs[0];
    host_write({1'b1, 10'd0, 5'd9, 16'h0200});
    repeat (100) @(negedge clk);
    host_write({1'b0, 10'd0, 5'd0, 16'h1200});
    chk(host_rdata == {1'b1, 10'd0, 5'd9, 16'h0200}, "R7 word unchanged",
        64'(host_rdata), 64'({1'b1, 10'd0, 5'd9, 16'h0200}));
    wait_flag(1'b0, "R7 first frame completes");
    repeat (CLK_DIV * 4) @(negedge clk);
    chk(frames == f0 + 1, "R7 single frame", 64'(frames), 64'(f0 + 1));
    chk(phy_regs[9] == 16'h0200, "R7 first write landed", 64'(phy_regs[9]), 64'h0200);
    chk(phy_regs[0] == keep0, "R7 dropped write absent", 64'(phy_regs[0]), 64'(keep0));
    chk(host_rdata[31] == 1'b0, "R7 no read started", 64'(host_rdata[31]), 64'd0);
  endtask

  task automatic t_clock();
    chk(per_min == CLK_DIV * 10.0 && per_max == CLK_DIV * 10.0, "R6 mdc period",
        64'(int'(per_max)), 64'(CLK_DIV * 10));
    chk(rcnt == 0, "R6 64 edges per frame", 64'(rcnt), 64'd0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) phy_regs[i] = 16'(i * 16'h0101);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write(5'd4, 16'h01E1);
    t_read(5'd1, 16'h796D);
    t_read(5'd4, 16'h01E1);
    t_read(5'd31, 16'hFFFF);
    t_read(5'd2, 16'h0000);
    t_busy_drop();
    t_write(5'd0, 16'h1200);
    t_clock();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #3_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule